// File: doc/BRIEF.md
# Sideband Mailbox Register Front End

This block is the device-side register set of a message-bus mailbox that a host reaches through a small configuration-style register port. It has three 32-bit registers: a command word, an extended-offset word and a data word. Writing the command word is the only thing that starts a sideband transaction. That transaction is one register read or one register write, sent to a target unit over a simple request/done port.

To write, the host first loads the data word. It then loads the extended offset when that offset is nonzero, and last it writes the command word. To read, the host loads the extended offset when needed, writes the command word, waits for the busy flag to clear and then reads the data word.

The target address is built by joining two parts. The upper 24 bits come from the extended register. The low byte comes from bits 15:8 of the command word. One target port number is never forwarded. A command that names it, or any command issued while no device is present, sets a sticky error bit instead of starting a transaction.

Top module: `mbox_front`

## Requirements
- R1: After reset every register reads zero, and busy, errStatus and sbReq are all low.
- R2: Register selects are 0 for command, 1 for extended, 2 for data, and 3 reads zero. A write to the extended register keeps bits 31:8, so its low byte always reads zero. A write to the data register stores all 32 bits.
- R3: A command write is accepted only when all of the following hold: the enable field (bits 7:0) equals 0xF0, the block is idle, devPresent is high and the port is allowed. One cycle after the write edge of an accepted command:
  - busy and sbReq are high;
  - sbOpcode is bits 31:24 and sbPort is bits 23:16;
  - sbOffset is {extended[31:8], command[15:8]};
  - sbWrData is the data register;
  - the command register reads back the written word.
- R4: Opcode bit 0 set gives sbWrite = 1, which is a write transaction. When a write completes, the data register is left unchanged.
- R5: On the edge where sbDone is sampled high while busy, busy and sbReq fall. For a read (sbWrite = 0), the data register takes the value of sbRdData on that same edge.
- R6: A command write whose enable field is not 0xF0 has no effect on busy, errStatus or any register.
- R7: While busy, all host writes are dropped, including command, extended and data writes. A data read returns the last completed value.
- R8: A command naming the refused port (0x06 by default) issues no request. It sets errStatus and leaves the command register unchanged.
- R9: A command with the correct enable field that arrives while devPresent is low issues no request and sets errStatus.
- R10: errStatus stays set until the next accepted command clears it.
- R11: While busy, the sideband port, opcode and offset hold steady until sbDone. A sbDone pulse while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 2 | Register select |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Selected register contents (combinational) |
| devPresent | input | 1 | Mailbox device available |
| busy | output | 1 | Transaction in flight |
| errStatus | output | 1 | Sticky refusal/absent-device error |
| sbReq | output | 1 | Sideband request, held until done |
| sbWrite | output | 1 | 1 = write transaction |
| sbPort | output | 8 | Target port |
| sbOpcode | output | 8 | Target opcode |
| sbOffset | output | 32 | Full target offset |
| sbWrData | output | 32 | Write data for the target |
| sbRdData | input | 32 | Read data from the target |
| sbDone | input | 1 | Responder completion pulse |

## Verification
The bench aims at the awkward orderings:
- A command, extended or data write that lands while busy. A design that accepted it would relaunch the transaction or corrupt the pending read result.
- A done pulse on a write. A design that captured the response bus on every completion would overwrite the data word with garbage.
- A refused port, an absent device and a bad enable field. These are told apart by whether errStatus moves, and a later good command must clear the error.
- A done pulse while idle. This must change nothing.
- An extended register written with a nonzero low byte. A design that did not mask that byte would build the wrong offset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 8;
  localparam int HI_W    = WORD_W - FIELD_W;
  localparam int OP_LSB   = 3 * FIELD_W;
  localparam int PORT_LSB = 2 * FIELD_W;
  localparam int OFF_LSB  = FIELD_W;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_EXT  = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } state_e;

  typedef struct packed {
    logic launch;
    logic loadExt;
    logic loadData;
    logic capture;
    logic setErr;
  } ctrlStrb_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter logic [FIELD_W-1:0] ENABLE_CODE  = 8'hF0,
  parameter logic [FIELD_W-1:0] REFUSED_PORT = 8'h06
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hostWrEn,
  input  logic [1:0]         hostAddr,
  input  logic [FIELD_W-1:0] cmdEnable,
  input  logic [FIELD_W-1:0] cmdPort,
  input  logic               devPresent,
  input  logic               sbDone,
  output ctrlStrb_t          strb,
  output logic               busy
);
  state_e state, stateNext;
  logic   idleWr;
  logic   cmdHit;
  logic   enableOk;
  logic   refuse;

  assign idleWr   = (state == ST_IDLE) && hostWrEn;
  assign cmdHit   = idleWr && (regSel_e'(hostAddr) == REG_CMD);
  assign enableOk = (cmdEnable == ENABLE_CODE);
  assign refuse   = !devPresent || (cmdPort == REFUSED_PORT);

  always_comb begin
    strb          = '0;
    strb.launch   = cmdHit && enableOk && !refuse;
    strb.setErr   = cmdHit && enableOk && refuse;
    strb.loadExt  = idleWr && (regSel_e'(hostAddr) == REG_EXT);
    strb.loadData = idleWr && (regSel_e'(hostAddr) == REG_DATA);
    strb.capture  = (state == ST_BUSY) && sbDone;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strb.launch) stateNext = ST_BUSY;
      ST_BUSY: if (sbDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy = (state == ST_BUSY);
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrb_t         strb,
  input  logic [1:0]        hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  input  logic [WORD_W-1:0] sbRdData,
  output logic              errStatus,
  output logic              sbReq,
  output logic              sbWrite,
  output logic [FIELD_W-1:0] sbPort,
  output logic [FIELD_W-1:0] sbOpcode,
  output logic [WORD_W-1:0] sbOffset,
  output logic [WORD_W-1:0] sbWrData
);
  logic [WORD_W-1:0] cmdReg;
  logic [HI_W-1:0]   extHi;
  logic [WORD_W-1:0] dataReg;

  // host-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg  <= '0;
      extHi   <= '0;
      dataReg <= '0;
    end else begin
      if (strb.launch)  cmdReg <= hostWrData;
      if (strb.loadExt) extHi  <= hostWrData[WORD_W-1:FIELD_W];
      if (strb.capture && !sbWrite) dataReg <= sbRdData;
      else if (strb.loadData)       dataReg <= hostWrData;
    end
  end

  // error flag: set on refusal, cleared by an accepted command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            errStatus <= 1'b0;
    else if (strb.setErr)  errStatus <= 1'b1;
    else if (strb.launch)  errStatus <= 1'b0;
  end

  // sideband request fields, snapshot at launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbReq    <= 1'b0;
      sbWrite  <= 1'b0;
      sbPort   <= '0;
      sbOpcode <= '0;
      sbOffset <= '0;
      sbWrData <= '0;
    end else if (strb.launch) begin
      sbReq    <= 1'b1;
      sbOpcode <= hostWrData[OP_LSB +: FIELD_W];
      sbWrite  <= hostWrData[OP_LSB];
      sbPort   <= hostWrData[PORT_LSB +: FIELD_W];
      sbOffset <= {extHi, hostWrData[OFF_LSB +: FIELD_W]};
      sbWrData <= dataReg;
    end else if (strb.capture) begin
      sbReq <= 1'b0;
    end
  end

  always_comb begin
    case (regSel_e'(hostAddr))
      REG_CMD:  hostRdData = cmdReg;
      REG_EXT:  hostRdData = {extHi, {FIELD_W{1'b0}}};
      REG_DATA: hostRdData = dataReg;
      default:  hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/mbox_front.sv
module mbox_front
  import mbox_pkg::*;
#(
  parameter logic [7:0] ENABLE_CODE  = 8'hF0,
  parameter logic [7:0] REFUSED_PORT = 8'h06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  input  logic        devPresent,
  output logic        busy,
  output logic        errStatus,
  output logic        sbReq,
  output logic        sbWrite,
  output logic [7:0]  sbPort,
  output logic [7:0]  sbOpcode,
  output logic [31:0] sbOffset,
  output logic [31:0] sbWrData,
  input  logic [31:0] sbRdData,
  input  logic        sbDone
);
  ctrlStrb_t strb;

  mbox_ctrl #(
    .ENABLE_CODE (ENABLE_CODE),
    .REFUSED_PORT(REFUSED_PORT)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .cmdEnable (hostWrData[FIELD_W-1:0]),
    .cmdPort   (hostWrData[PORT_LSB +: FIELD_W]),
    .devPresent(devPresent),
    .sbDone    (sbDone),
    .strb      (strb),
    .busy      (busy)
  );

  mbox_dpath dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .sbRdData  (sbRdData),
    .errStatus (errStatus),
    .sbReq     (sbReq),
    .sbWrite   (sbWrite),
    .sbPort    (sbPort),
    .sbOpcode  (sbOpcode),
    .sbOffset  (sbOffset),
    .sbWrData  (sbWrData)
  );
endmodule

// File: rtl/mbox_front_chk.sv
module mbox_front_chk #(
  parameter logic [7:0] ENABLE_CODE  = 8'hF0,
  parameter logic [7:0] REFUSED_PORT = 8'h06
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hostWrEn,
  input logic [1:0]  hostAddr,
  input logic [31:0] hostWrData,
  input logic        busy,
  input logic        errStatus,
  input logic        sbReq,
  input logic [7:0]  sbPort,
  input logic [7:0]  sbOpcode,
  input logic [31:0] sbOffset,
  input logic        sbDone
);
  p_req_tracks_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sbReq == busy);

  p_launch_from_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hostWrEn && hostAddr == 2'd0 && hostWrData[7:0] == ENABLE_CODE));

  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sbDone |=> !busy);

  p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hostWrEn && hostAddr == 2'd0 && hostWrData[7:0] != ENABLE_CODE)
      |=> !busy && $stable(errStatus));

  p_never_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sbReq |-> sbPort != REFUSED_PORT);

  p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errStatus) |-> $past(hostWrEn && hostAddr == 2'd0 && !busy));

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(errStatus) |-> $rose(busy));

  p_hold_until_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sbDone |=> busy && $stable(sbOffset) && $stable(sbPort) && $stable(sbOpcode));
endmodule

bind mbox_front mbox_front_chk #(
  .ENABLE_CODE (ENABLE_CODE),
  .REFUSED_PORT(REFUSED_PORT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .hostWrEn  (hostWrEn),
  .hostAddr  (hostAddr),
  .hostWrData(hostWrData),
  .busy      (busy),
  .errStatus (errStatus),
  .sbReq     (sbReq),
  .sbPort    (sbPort),
  .sbOpcode  (sbOpcode),
  .sbOffset  (sbOffset),
  .sbDone    (sbDone)
);

// File: tb/mbox_front_tb_top.sv
module mbox_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        devPresent = 1'b1;
  logic        busy, errStatus, sbReq, sbWrite;
  logic [7:0]  sbPort, sbOpcode;
  logic [31:0] sbOffset, sbWrData;
  logic [31:0] sbRdData = '0;
  logic        sbDone = 1'b0;

  always #4 clk = ~clk;

  mbox_front dut_i (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .devPresent(devPresent),
    .busy(busy), .errStatus(errStatus), .sbReq(sbReq), .sbWrite(sbWrite),
    .sbPort(sbPort), .sbOpcode(sbOpcode), .sbOffset(sbOffset),
    .sbWrData(sbWrData), .sbRdData(sbRdData), .sbDone(sbDone)
  );

  // behavioural reference model
  logic [31:0] mCmd = '0, mExt = '0, mData = '0, mOff = '0, mWd = '0;
  logic [7:0]  mPort = '0, mOp = '0;
  logic        mBusy = 1'b0, mErr = 1'b0, mWrite = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCmd = '0; mExt = '0; mData = '0; mOff = '0; mWd = '0;
      mPort = '0; mOp = '0; mBusy = 1'b0; mErr = 1'b0; mWrite = 1'b0;
    end else if (mBusy) begin
      if (sbDone) begin
        mBusy = 1'b0;
        if (!mWrite) mData = sbRdData;
      end
    end else if (hostWrEn) begin
      if (hostAddr == 2'd1) mExt = hostWrData & 32'hFFFF_FF00;
      else if (hostAddr == 2'd2) mData = hostWrData;
      else if (hostAddr == 2'd0 && hostWrData[7:0] == 8'hF0) begin
        if (!devPresent || hostWrData[23:16] == 8'h06) mErr = 1'b1;
        else begin
          mErr = 1'b0; mBusy = 1'b1; mCmd = hostWrData;
          mOp = hostWrData[31:24]; mPort = hostWrData[23:16];
          mWrite = hostWrData[24];
          mOff = {mExt[31:8], hostWrData[15:8]};
          mWd = mData;
        end
      end
    end
  end

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R1";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [31:0] expRd;
    case (hostAddr)
      2'd0: expRd = mCmd;
      2'd1: expRd = mExt;
      2'd2: expRd = mData;
      default: expRd = '0;
    endcase
    chk("hostRdData", hostRdData, expRd);
    chk("busy", {31'd0, busy}, {31'd0, mBusy});
    chk("sbReq", {31'd0, sbReq}, {31'd0, mBusy});
    chk("errStatus", {31'd0, errStatus}, {31'd0, mErr});
    chk("sbWrite", {31'd0, sbWrite}, {31'd0, mWrite});
    chk("sbPort", {24'd0, sbPort}, {24'd0, mPort});
    chk("sbOpcode", {24'd0, sbOpcode}, {24'd0, mOp});
    chk("sbOffset", sbOffset, mOff);
    chk("sbWrData", sbWrData, mWd);
  endtask

  task automatic tick(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic dn, input logic [31:0] rd);
    @(negedge clk);
    compareAll();
    hostWrEn = we; hostAddr = a; hostWrData = d; sbDone = dn; sbRdData = rd;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) tick(1'b0, a, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic run();
    curReq = "R1";
    repeat (3) @(posedge clk);
    idle(1, 2'd0); idle(1, 2'd1); idle(1, 2'd2); idle(1, 2'd3);
    rst_n = 1'b1;
    idle(2, 2'd3);

    curReq = "R2";
    tick(1'b1, 2'd1, 32'h1234_5678, 1'b0, 0);
    tick(1'b1, 2'd2, 32'hCAFE_0001, 1'b0, 0);
    idle(1, 2'd1); idle(1, 2'd2); idle(1, 2'd3);

    curReq = "R3";
    tick(1'b1, 2'd0, 32'h0103_9AF0, 1'b0, 0);
    idle(2, 2'd0);

    curReq = "R7";
    tick(1'b1, 2'd0, 32'h1005_11F0, 1'b0, 0);
    tick(1'b1, 2'd2, 32'h5555_AAAA, 1'b0, 0);
    tick(1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 0);
    idle(1, 2'd2); idle(1, 2'd1);

    curReq = "R4";
    tick(1'b0, 2'd2, 0, 1'b1, 32'hBAD0_BAD0);
    idle(2, 2'd2);

    curReq = "R5";
    tick(1'b1, 2'd1, 32'h0000_0000, 1'b0, 0);
    tick(1'b1, 2'd0, 32'h1005_44F0, 1'b0, 0);
    idle(3, 2'd2);
    tick(1'b0, 2'd2, 0, 1'b1, 32'hDEAD_BEEF);
    idle(2, 2'd2);

    curReq = "R11";
    tick(1'b0, 2'd2, 0, 1'b1, 32'h7777_7777);
    idle(2, 2'd2);

    curReq = "R6";
    tick(1'b1, 2'd0, 32'h2207_33A0, 1'b0, 0);
    idle(2, 2'd0);

    curReq = "R8";
    tick(1'b1, 2'd0, 32'h2206_33F0, 1'b0, 0);
    idle(2, 2'd0);

    curReq = "R6";
    tick(1'b1, 2'd0, 32'h2207_3300, 1'b0, 0);
    idle(1, 2'd0);

    curReq = "R10";
    tick(1'b1, 2'd1, 32'hABCD_EF12, 1'b0, 0);
    tick(1'b1, 2'd0, 32'h2207_33F0, 1'b0, 0);
    idle(2, 2'd0);
    tick(1'b0, 2'd2, 0, 1'b1, 32'h0BAD_F00D);
    idle(1, 2'd2);

    curReq = "R9";
    devPresent = 1'b0;
    tick(1'b1, 2'd0, 32'h3108_01F0, 1'b0, 0);
    idle(2, 2'd0);
    devPresent = 1'b1;

    curReq = "R10";
    tick(1'b1, 2'd2, 32'h0F0F_0F0F, 1'b0, 0);
    tick(1'b1, 2'd0, 32'h3108_01F0, 1'b0, 0);
    idle(1, 2'd0);
    tick(1'b0, 2'd0, 0, 1'b1, 32'h1111_2222);
    idle(3, 2'd2);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule